// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR4-class SDRAM link. It runs once after every controller reset. It takes the attached device from power-on to the idle state, and during that time it owns the device reset pin, the clock enable and the command pins. First it holds the device in reset for a programmable number of cycles. After releasing reset it waits a settling interval with the command bus deselected, then raises clock enable. After a further exit delay it loads all seven mode registers with fixed values. Last, it issues a long calibration command and signals completion.

The mode registers are loaded in a fixed order that ends with register 0. Each load selects its register through the bank-group and bank pins and carries the register value on the address pins. Every wait is a parameter in clock cycles. One shared down-counter times all of them. The register values are parameters too, and their defaults keep the optional power, latency, parity, repair and rate features switched off. After the done flag rises, the controller's normal traffic scheduler takes over the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `mem_reset_n`=0, `mem_cke`=0, `mem_cs_n`=0 and `init_done`=0. Chip select low with clock enable low is the device reset condition.
- R2: Counting the cycle before the first clock edge after `rst_n` rises as cycle 0, `mem_reset_n` is 0 in cycles 0 to T_RESET_HOLD-1 and is 1 from then on.
- R3: `mem_cke` stays 0 until cycle T_RESET_HOLD+T_CKE_SETTLE and is 1 from then until the next reset. Whenever `mem_cke` is 0 and `mem_reset_n` is 1, the bus is deselected (`mem_cs_n`=1).
- R4: The first mode register command comes exactly max(T_XS,5) cycles after `mem_cke` rises.
- R5: Seven mode register commands are issued in the register order 3, 6, 5, 4, 2, 1, 0. Each one drives `mem_cs_n`=0, `mem_act_n`=1, `mem_ras_n`=0, `mem_cas_n`=0 and `mem_we_n`=0. The pins carry `mem_bg[0]` = register number bit 2, `mem_bg[1]`=0, `mem_ba` = register number bits 1:0, and `mem_addr` = that register's parameter value.
- R6: Consecutive mode register commands are exactly T_MRD cycles apart. The calibration command follows the register 0 command by exactly T_MOD cycles.
- R7: The calibration command drives `mem_cs_n`=0, `mem_act_n`=1, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=0, `mem_bg`=0 and `mem_ba`=0. On `mem_addr`, only bit 10 is set.
- R8: `init_done` rises exactly max(T_DLLK,T_ZQINIT) cycles after the calibration command. It stays high and the bus stays deselected until the next reset.
- R9: With default parameters, the register-3 value has bits 4:3 equal to 0 (per-device addressing off, half-rate gear-down). The register-4 value has bit 1, bits 8:6 and bit 13 equal to 0 (max power saving off, chip-select-to-command latency off, hard repair off). The register-5 value has bits 2:0 equal to 0 (command/address parity latency off).
- R10: After the reset hold, `mem_cs_n` is 0 only in the eight command cycles.
- R11: Asserting `rst_n` in the middle of the sequence returns all outputs to the R1 state at once. The next release replays the whole schedule from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the device command clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| mem_reset_n | output | 1 | Active-low device reset |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_act_n | output | 1 | Activate strobe, held high by this block |
| mem_ras_n | output | 1 | Row strobe command bit |
| mem_cas_n | output | 1 | Column strobe command bit |
| mem_we_n | output | 1 | Write-enable command bit |
| mem_bg | output | BG_W | Bank group, selects the mode register together with `mem_ba` |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus, carries mode register values and the calibration flag |
| init_done | output | 1 | High once the sequence has finished |

## Verification
Two instances run side by side with different timing sets. In one, T_XS is above 5 and the calibration wait is set by T_DLLK. In the other, T_XS is below 5 and T_ZQINIT sets the wait. A design that ignores either maximum therefore shifts one schedule and is caught. Every cycle of each schedule is compared for reset, clock enable, chip select and done. In each command cycle, a table of expected register numbers and values tells the load order, the bank encoding and the value routing apart. A reset that lands between two register loads, followed by a full replay, separates a true restart from a counter or step index that resumes where it stopped.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        PH_RST_HOLD,
        PH_SETTLE,
        PH_XPR,
        PH_MRS_CMD,
        PH_MRS_GAP,
        PH_MOD_GAP,
        PH_ZQ_CMD,
        PH_ZQ_WAIT,
        PH_DONE
    } phase_e;

    localparam int NUM_MRS = 7;

    typedef struct packed {
        logic reset_n;
        logic cke;
        logic cs_n;
        logic act_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ctl_pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Load order: step 0..6 maps to registers 3,6,5,4,2,1,0.
    function automatic logic [2:0] mr_for_step(input logic [2:0] step);
        logic [2:0] r;
        case (step)
            3'd0:    r = 3'd3;
            3'd1:    r = 3'd6;
            3'd2:    r = 3'd5;
            3'd3:    r = 3'd4;
            3'd4:    r = 3'd2;
            3'd5:    r = 3'd1;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2,
    parameter int ZQ_BIT = 10
) (
    input  phase_e            phase_i,
    input  logic [2:0]        mr_sel_i,
    input  logic [ADDR_W-1:0] mr_val_i,
    output ctl_pins_t         pins_o,
    output logic [BG_W-1:0]   bg_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        pins_o = '{reset_n: 1'b1, cke: 1'b1, cs_n: 1'b1, act_n: 1'b1,
                   ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        bg_o   = '0;
        ba_o   = '0;
        addr_o = '0;
        case (phase_i)
            PH_RST_HOLD: begin
                pins_o.reset_n = 1'b0;
                pins_o.cke     = 1'b0;
                pins_o.cs_n    = 1'b0;
            end
            PH_SETTLE: begin
                pins_o.cke = 1'b0;
            end
            PH_MRS_CMD: begin
                pins_o.cs_n  = 1'b0;
                pins_o.ras_n = 1'b0;
                pins_o.cas_n = 1'b0;
                pins_o.we_n  = 1'b0;
                bg_o   = BG_W'(mr_sel_i[2]);
                ba_o   = BA_W'(mr_sel_i[1:0]);
                addr_o = mr_val_i;
            end
            PH_ZQ_CMD: begin
                pins_o.cs_n    = 1'b0;
                pins_o.we_n    = 1'b0;
                addr_o[ZQ_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int BG_W         = 2,
    parameter int BA_W         = 2,
    parameter int T_RESET_HOLD = 20,
    parameter int T_CKE_SETTLE = 30,
    parameter int T_XS         = 8,
    parameter int T_MRD        = 8,
    parameter int T_MOD        = 24,
    parameter int T_DLLK       = 64,
    parameter int T_ZQINIT     = 48,
    parameter logic [ADDR_W-1:0] MR0_VAL = ADDR_W'(18'h00124),
    parameter logic [ADDR_W-1:0] MR1_VAL = ADDR_W'(18'h00001),
    parameter logic [ADDR_W-1:0] MR2_VAL = ADDR_W'(18'h00008),
    parameter logic [ADDR_W-1:0] MR3_VAL = ADDR_W'(18'h00000),
    parameter logic [ADDR_W-1:0] MR4_VAL = ADDR_W'(18'h00000),
    parameter logic [ADDR_W-1:0] MR5_VAL = ADDR_W'(18'h00400),
    parameter logic [ADDR_W-1:0] MR6_VAL = ADDR_W'(18'h00800)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_reset_n,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_act_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BG_W-1:0]   mem_bg,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);

    // Durations in cycles; gaps after a one-cycle command need at least 2.
    localparam int D_RST    = imax(T_RESET_HOLD, 1);
    localparam int D_SETTLE = imax(T_CKE_SETTLE, 1);
    localparam int D_XPR    = imax(T_XS, 5);
    localparam int D_MRD    = imax(T_MRD, 2);
    localparam int D_MOD    = imax(T_MOD, 2);
    localparam int D_ZQ     = imax(imax(T_DLLK, T_ZQINIT), 2);
    localparam int LONGEST  = imax(imax(imax(D_RST, D_SETTLE), imax(D_XPR, D_MRD)),
                                   imax(D_MOD, D_ZQ));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(D_SETTLE - 1);
    localparam logic [CNT_W-1:0] XPR_LD    = CNT_W'(D_XPR - 1);
    localparam logic [CNT_W-1:0] MRD_LD    = CNT_W'(D_MRD - 2);
    localparam logic [CNT_W-1:0] MOD_LD    = CNT_W'(D_MOD - 2);
    localparam logic [CNT_W-1:0] ZQ_LD     = CNT_W'(D_ZQ - 2);
    localparam logic [2:0]       LAST_STEP = 3'(NUM_MRS - 1);

    typedef struct packed {
        phase_e     phase;
        logic [2:0] step;
    } seq_t;

    seq_t             cur_q, nx_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [2:0]       mr_sel;
    logic [ADDR_W-1:0] mr_val;
    ctl_pins_t        pins;

    sdram_init_timer #(
        .W       (CNT_W),
        .RST_VAL (D_RST - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        nx_d     = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (cur_q.phase)
            PH_RST_HOLD: if (tmr_expired) begin
                nx_d.phase = PH_SETTLE;
                tmr_load   = 1'b1;
                tmr_val    = SETTLE_LD;
            end
            PH_SETTLE: if (tmr_expired) begin
                nx_d.phase = PH_XPR;
                tmr_load   = 1'b1;
                tmr_val    = XPR_LD;
            end
            PH_XPR: if (tmr_expired) begin
                nx_d.phase = PH_MRS_CMD;
            end
            PH_MRS_CMD: begin
                tmr_load = 1'b1;
                if (cur_q.step == LAST_STEP) begin
                    nx_d.phase = PH_MOD_GAP;
                    tmr_val    = MOD_LD;
                end else begin
                    nx_d.phase = PH_MRS_GAP;
                    tmr_val    = MRD_LD;
                end
            end
            PH_MRS_GAP: if (tmr_expired) begin
                nx_d.phase = PH_MRS_CMD;
                nx_d.step  = cur_q.step + 3'd1;
            end
            PH_MOD_GAP: if (tmr_expired) begin
                nx_d.phase = PH_ZQ_CMD;
            end
            PH_ZQ_CMD: begin
                nx_d.phase = PH_ZQ_WAIT;
                tmr_load   = 1'b1;
                tmr_val    = ZQ_LD;
            end
            PH_ZQ_WAIT: if (tmr_expired) begin
                nx_d.phase = PH_DONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '{phase: PH_RST_HOLD, step: 3'd0};
        else
            cur_q <= nx_d;
    end

    assign mr_sel = mr_for_step(cur_q.step);

    always_comb begin
        case (mr_sel)
            3'd0:    mr_val = MR0_VAL;
            3'd1:    mr_val = MR1_VAL;
            3'd2:    mr_val = MR2_VAL;
            3'd3:    mr_val = MR3_VAL;
            3'd4:    mr_val = MR4_VAL;
            3'd5:    mr_val = MR5_VAL;
            default: mr_val = MR6_VAL;
        endcase
    end

    sdram_init_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BG_W   (BG_W),
        .BA_W   (BA_W),
        .ZQ_BIT (10)
    ) u_enc (
        .phase_i  (cur_q.phase),
        .mr_sel_i (mr_sel),
        .mr_val_i (mr_val),
        .pins_o   (pins),
        .bg_o     (mem_bg),
        .ba_o     (mem_ba),
        .addr_o   (mem_addr)
    );

    assign mem_reset_n = pins.reset_n;
    assign mem_cke     = pins.cke;
    assign mem_cs_n    = pins.cs_n;
    assign mem_act_n   = pins.act_n;
    assign mem_ras_n   = pins.ras_n;
    assign mem_cas_n   = pins.cas_n;
    assign mem_we_n    = pins.we_n;
    assign init_done   = (cur_q.phase == PH_DONE);

    assert_hold_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_reset_n |-> (!mem_cke && !mem_cs_n && !init_done));

    assert_reset_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_reset_n |=> mem_reset_n);

    assert_cke_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cke |=> mem_cke);

    assert_settle_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_reset_n && !mem_cke) |-> mem_cs_n);

    assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.step < 3'(NUM_MRS));

    assert_mrs_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_cke && !mem_ras_n) |-> (mem_bg[BG_W-1:1] == '0));

    assert_cmd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_cke) |=> mem_cs_n);

    assert_zq_after_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_cke && mem_ras_n && !mem_we_n) |-> (cur_q.step == LAST_STEP));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> mem_cs_n);

endmodule

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;

    // Instance 0: T_XS above 5, T_DLLK dominates. Instance 1: the reverse.
    localparam int A_RST = 20, A_SET = 30, A_XS = 8, A_MRD = 8, A_MOD = 24, A_DLLK = 64, A_ZQ = 48;
    localparam int B_RST = 16, B_SET = 24, B_XS = 3, B_MRD = 4, B_MOD = 12, B_DLLK = 40, B_ZQ = 70;

    // {register number, value}; entry 7 is the calibration command (number field unused).
    localparam logic [20:0] CMD_TBL [8] = '{
        {3'd3, 18'h00000}, {3'd6, 18'h00800}, {3'd5, 18'h00400}, {3'd4, 18'h00000},
        {3'd2, 18'h00008}, {3'd1, 18'h00001}, {3'd0, 18'h00124}, {3'd7, 18'h00400}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] o_reset_n, o_cke, o_cs_n, o_act_n, o_ras_n, o_cas_n, o_we_n, o_done;
    logic [1:0]  o_bg   [2];
    logic [1:0]  o_ba   [2];
    logic [17:0] o_addr [2];

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_init_seq #(
        .T_RESET_HOLD(A_RST), .T_CKE_SETTLE(A_SET), .T_XS(A_XS), .T_MRD(A_MRD),
        .T_MOD(A_MOD), .T_DLLK(A_DLLK), .T_ZQINIT(A_ZQ)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n),
        .mem_reset_n(o_reset_n[0]), .mem_cke(o_cke[0]), .mem_cs_n(o_cs_n[0]),
        .mem_act_n(o_act_n[0]), .mem_ras_n(o_ras_n[0]), .mem_cas_n(o_cas_n[0]),
        .mem_we_n(o_we_n[0]), .mem_bg(o_bg[0]), .mem_ba(o_ba[0]),
        .mem_addr(o_addr[0]), .init_done(o_done[0])
    );

    sdram_init_seq #(
        .T_RESET_HOLD(B_RST), .T_CKE_SETTLE(B_SET), .T_XS(B_XS), .T_MRD(B_MRD),
        .T_MOD(B_MOD), .T_DLLK(B_DLLK), .T_ZQINIT(B_ZQ)
    ) u_sdram_init_seq_alt (
        .clk(clk), .rst_n(rst_n),
        .mem_reset_n(o_reset_n[1]), .mem_cke(o_cke[1]), .mem_cs_n(o_cs_n[1]),
        .mem_act_n(o_act_n[1]), .mem_ras_n(o_ras_n[1]), .mem_cas_n(o_cas_n[1]),
        .mem_we_n(o_we_n[1]), .mem_bg(o_bg[1]), .mem_ba(o_ba[1]),
        .mem_addr(o_addr[1]), .init_done(o_done[1])
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int t_rst(input int i);
        return (i == 0) ? A_RST : B_RST;
    endfunction

    function automatic int t_cke(input int i);
        return (i == 0) ? A_RST + A_SET : B_RST + B_SET;
    endfunction

    function automatic int t_mrs(input int i, input int n);
        return (i == 0) ? t_cke(0) + mx(A_XS, 5) + n * A_MRD
                        : t_cke(1) + mx(B_XS, 5) + n * B_MRD;
    endfunction

    function automatic int t_zq(input int i);
        return t_mrs(i, 6) + ((i == 0) ? A_MOD : B_MOD);
    endfunction

    function automatic int t_done(input int i);
        return t_zq(i) + ((i == 0) ? mx(A_DLLK, A_ZQ) : mx(B_DLLK, B_ZQ));
    endfunction

    task automatic chk(input string tag, input int inst, input int cyc,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s inst=%0d cycle=%0d actual=%0h expected=%0h", tag, inst, cyc, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(tag, i, -1, 32'({o_reset_n[i], o_cke[i], o_cs_n[i], o_done[i]}), 32'b0000);
        end
    endtask

    task automatic check_cycle(input int i, input int k);
        int    cmd;
        string cs_tag;
        logic [20:0] ent;
        cmd = -1;
        for (int n = 0; n < 7; n++) if (k == t_mrs(i, n)) cmd = n;
        if (k == t_zq(i)) cmd = 7;
        chk("R2", i, k, 32'(o_reset_n[i]), 32'(k >= t_rst(i)));
        chk("R3", i, k, 32'(o_cke[i]), 32'(k >= t_cke(i)));
        chk((k == t_done(i)) ? "R8 edge" : "R8", i, k, 32'(o_done[i]), 32'(k >= t_done(i)));
        if (cmd == 0)      cs_tag = "R4";
        else if (cmd > 0)  cs_tag = "R6";
        else               cs_tag = "R10";
        chk(cs_tag, i, k, 32'(o_cs_n[i]), 32'(!(k < t_rst(i) || cmd >= 0)));
        if (cmd >= 0 && cmd < 7) begin
            ent = CMD_TBL[cmd];
            chk("R5 ctl",  i, k, 32'({o_act_n[i], o_ras_n[i], o_cas_n[i], o_we_n[i]}), 32'b1000);
            chk("R5 bg",   i, k, 32'(o_bg[i]), 32'({1'b0, ent[20]}));
            chk("R5 ba",   i, k, 32'(o_ba[i]), 32'(ent[19:18]));
            chk("R5 addr", i, k, 32'(o_addr[i]), 32'(ent[17:0]));
            if (ent[20:18] == 3'd3) chk("R9 mr3", i, k, 32'(o_addr[i][4:3]), 32'd0);
            if (ent[20:18] == 3'd4)
                chk("R9 mr4", i, k, 32'({o_addr[i][13], o_addr[i][8:6], o_addr[i][1]}), 32'd0);
            if (ent[20:18] == 3'd5) chk("R9 mr5", i, k, 32'(o_addr[i][2:0]), 32'd0);
        end
        if (cmd == 7) begin
            chk("R7 ctl",  i, k, 32'({o_act_n[i], o_ras_n[i], o_cas_n[i], o_we_n[i]}), 32'b1110);
            chk("R7 bgba", i, k, 32'({o_bg[i], o_ba[i]}), 32'd0);
            chk("R7 addr", i, k, 32'(o_addr[i]), 32'h00400);
        end
    endtask

    // Called at a falling edge with rst_n just released: cycle 0 is now.
    task automatic walk(input int len);
        for (int k = 0; k <= len; k++) begin
            if (k > 0) @(negedge clk);
            check_cycle(0, k);
            check_cycle(1, k);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;
        walk(230);

        // Reset during an idle done state.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R1 after done");
        repeat (2) @(negedge clk);

        // Reset in the middle of the register loads, then a full replay (R11).
        rst_n = 1'b1;
        walk(100);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R11 mid");
        repeat (2) @(negedge clk);
        check_reset_state("R11 held");
        rst_n = 1'b1;
        walk(230);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule